// File: doc/BRIEF.md
# Access Privilege Gate

This block decides, for every memory access, at which privilege level the access is judged and whether the translated page grants it. Each access arrives as a kind (fetch, load or store), the page's permission bits and the hart's status context. The block answers one cycle later with the effective privilege and an allow or fault verdict. The status context is the current privilege, the saved previous privilege and the executable-readable control.

The block also holds the writable substitute-privilege bit. When this bit is set, loads and stores are judged at the saved previous privilege instead of the current one. Instruction fetches never use the substitution. When the design is built without user mode, the bit reads as zero at all times and writes to it are dropped. Page walking, translation caching and trap delivery belong to neighbouring blocks.

Top module: `acc_priv_gate`

## Requirements
- R1: While `rst` is high and after it falls, until the first access is presented: `ovr_q`, `res_valid`, `res_priv`, `res_allow` and `res_fault` are all 0.
- R2: With `HAS_USER`=1, a cycle with `ovr_wr_en`=1 loads `ovr_wr_data` into the substitute bit, and `ovr_q` shows it after that clock edge. An access in the same cycle as the write still uses the old value.
- R3: A fetch (`acc_kind`=00) is always judged at the current privilege, whatever the substitute bit holds.
- R4: A load (`acc_kind`=01) or store (`acc_kind`=10) is judged at the current privilege when the substitute bit is 0, and at `prev_priv` when it is 1. This holds in every current privilege.
- R5: Privilege codes are 00 user, 01 supervisor and 11 machine. Code 10 is treated as user, and `res_priv` then reports 00.
- R6: At effective machine privilege, any fetch, load or store is allowed whatever the page bits are.
- R7: A load needs `pg_r`=1. When `exec_rd`=1, a load is also granted on a page with `pg_x`=1.
- R8: A store needs `pg_w`=1 and a fetch needs `pg_x`=1. Otherwise the access faults.
- R9: At effective user privilege, a page with `pg_u`=0 faults. At effective supervisor privilege, a fetch from a page with `pg_u`=1 faults, while loads and stores there follow R7 and R8.
- R10: Results are registered. `res_valid` follows `acc_valid` one cycle later. `res_allow` and `res_fault` are never both 1, and both are 0 when `res_valid` is 0.
- R11: The reserved access kind 11 always faults and is judged at the current privilege.
- R12: With `HAS_USER`=0, `ovr_q` stays 0 after any write. Loads and stores are then judged at the current privilege.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_priv | input | 2 | Current privilege code |
| prev_priv | input | 2 | Saved previous privilege code |
| exec_rd | input | 1 | Lets loads read pages that are executable only |
| ovr_wr_en | input | 1 | Write strobe for the substitute-privilege bit |
| ovr_wr_data | input | 1 | Value written to the substitute-privilege bit |
| ovr_q | output | 1 | Current value of the substitute-privilege bit |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_kind | input | 2 | 00 fetch, 01 load, 10 store, 11 reserved |
| pg_r | input | 1 | Page readable |
| pg_w | input | 1 | Page writable |
| pg_x | input | 1 | Page executable |
| pg_u | input | 1 | Page belongs to user mode |
| res_valid | output | 1 | Verdict for the access of the previous cycle |
| res_priv | output | 2 | Effective privilege used for that access |
| res_allow | output | 1 | Access granted |
| res_fault | output | 1 | Access fault |

## Verification
Some properties are checked by the assertions on every cycle. These are the one-cycle timing of the result, the exclusivity of allow and fault, the forced-zero substitute bit without user mode, and faults on reserved kinds and on stores to non-writable pages. Fetches are checked to follow the current privilege, and a machine-level substitution is checked to grant loads and stores. The bench scenarios cover the rest. They show which privilege each combination of mode, substitute bit and access kind produces, and the user and supervisor page-ownership rules. They also cover the executable-readable override and the ordering of a write to the substitute bit against an access in the same cycle.

// File: rtl/acc_priv_pkg.sv
package acc_priv_pkg;

  typedef enum logic [1:0] {
    PRV_USER  = 2'b00,
    PRV_SUPER = 2'b01,
    PRV_RSVD  = 2'b10,
    PRV_MACH  = 2'b11
  } priv_e;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_LOAD  = 2'b01,
    ACC_STORE = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_kind_e;

  typedef struct packed {
    logic rd;
    logic wr;
    logic ex;
    logic usr;
  } page_perm_t;

  // The reserved code folds onto the least privileged level.
  function automatic priv_e fold_priv(input logic [1:0] code);
    if (code == PRV_RSVD) return PRV_USER;
    return priv_e'(code);
  endfunction

endpackage

// File: rtl/ovr_bit_reg.sv
module ovr_bit_reg #(
  parameter bit HAS_USER = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_data,
  output logic q
);

  generate
    if (HAS_USER) begin : g_store
      logic bit_q;
      always_ff @(posedge clk) begin
        if (rst)        bit_q <= 1'b0;
        else if (wr_en) bit_q <= wr_data;
      end
      assign q = bit_q;
    end else begin : g_tied
      logic unused_wr;
      assign unused_wr = ^{clk, rst, wr_en, wr_data};
      assign q = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/eff_priv_sel.sv
module eff_priv_sel
  import acc_priv_pkg::*;
(
  input  logic [1:0] cur_priv,
  input  logic [1:0] prev_priv,
  input  logic       ovr,
  input  acc_kind_e  kind,
  output priv_e      eff
);

  logic data_side;

  always_comb begin
    data_side = (kind == ACC_LOAD) || (kind == ACC_STORE);
    if (data_side && ovr) eff = fold_priv(prev_priv);
    else                  eff = fold_priv(cur_priv);
  end

endmodule

// File: rtl/page_perm_eval.sv
module page_perm_eval
  import acc_priv_pkg::*;
(
  input  priv_e      eff,
  input  acc_kind_e  kind,
  input  page_perm_t perm,
  input  logic       exec_rd,
  output logic       allow
);

  logic kind_ok;
  logic owner_ok;

  always_comb begin
    unique case (kind)
      ACC_LOAD:  kind_ok = perm.rd | (perm.ex & exec_rd);
      ACC_STORE: kind_ok = perm.wr;
      ACC_FETCH: kind_ok = perm.ex;
      default:   kind_ok = 1'b0;
    endcase

    unique case (eff)
      PRV_SUPER: owner_ok = !((kind == ACC_FETCH) && perm.usr);
      default:   owner_ok = perm.usr;
    endcase

    if (kind == ACC_RSVD)      allow = 1'b0;
    else if (eff == PRV_MACH)  allow = 1'b1;
    else                       allow = kind_ok & owner_ok;
  end

endmodule

// File: rtl/acc_priv_gate.sv
module acc_priv_gate
  import acc_priv_pkg::*;
#(
  parameter bit HAS_USER = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] cur_priv,
  input  logic [1:0] prev_priv,
  input  logic       exec_rd,
  input  logic       ovr_wr_en,
  input  logic       ovr_wr_data,
  output logic       ovr_q,
  input  logic       acc_valid,
  input  logic [1:0] acc_kind,
  input  logic       pg_r,
  input  logic       pg_w,
  input  logic       pg_x,
  input  logic       pg_u,
  output logic       res_valid,
  output logic [1:0] res_priv,
  output logic       res_allow,
  output logic       res_fault
);

  acc_kind_e  kind;
  page_perm_t perm;
  priv_e      eff;
  logic       allow;

  assign kind = acc_kind_e'(acc_kind);
  assign perm = '{rd: pg_r, wr: pg_w, ex: pg_x, usr: pg_u};

  ovr_bit_reg #(.HAS_USER(HAS_USER)) u_ovr (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (ovr_wr_en),
    .wr_data (ovr_wr_data),
    .q       (ovr_q)
  );

  eff_priv_sel u_sel (
    .cur_priv  (cur_priv),
    .prev_priv (prev_priv),
    .ovr       (ovr_q),
    .kind      (kind),
    .eff       (eff)
  );

  page_perm_eval u_perm (
    .eff     (eff),
    .kind    (kind),
    .perm    (perm),
    .exec_rd (exec_rd),
    .allow   (allow)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_priv  <= 2'b00;
      res_allow <= 1'b0;
      res_fault <= 1'b0;
    end else begin
      res_valid <= acc_valid;
      res_priv  <= acc_valid ? eff : PRV_USER;
      res_allow <= acc_valid & allow;
      res_fault <= acc_valid & ~allow;
    end
  end

endmodule

// File: rtl/acc_priv_gate_chk.sv
module acc_priv_gate_chk #(
  parameter bit HAS_USER = 1'b1
) (
  input logic       clk,
  input logic       rst,
  input logic [1:0] cur_priv,
  input logic [1:0] prev_priv,
  input logic       ovr_q,
  input logic       acc_valid,
  input logic [1:0] acc_kind,
  input logic       pg_w,
  input logic       res_valid,
  input logic [1:0] res_priv,
  input logic       res_allow,
  input logic       res_fault
);

  a_r10_valid_follows: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> res_valid);

  a_r10_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !res_valid);

  a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(res_allow && res_fault) && (res_valid || (!res_allow && !res_fault)));

  a_r3_fetch_cur: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_kind == 2'b00) |=>
      res_priv == (($past(cur_priv) == 2'b10) ? 2'b00 : $past(cur_priv)));

  a_r4_subst_mach: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && (acc_kind == 2'b01 || acc_kind == 2'b10) && ovr_q && prev_priv == 2'b11)
      |=> (res_priv == 2'b11) && res_allow);

  a_r8_store_nowr: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_kind == 2'b10 && !pg_w && !(ovr_q && prev_priv == 2'b11)
       && !(!ovr_q && cur_priv == 2'b11)) |=> res_fault);

  a_r11_rsvd_fault: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_kind == 2'b11) |=> res_fault);

  generate
    if (!HAS_USER) begin : g_nu
      a_r12_tied_zero: assert property (@(posedge clk) disable iff (rst) !ovr_q);
    end
  endgenerate

endmodule

bind acc_priv_gate acc_priv_gate_chk #(.HAS_USER(HAS_USER)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cur_priv  (cur_priv),
  .prev_priv (prev_priv),
  .ovr_q     (ovr_q),
  .acc_valid (acc_valid),
  .acc_kind  (acc_kind),
  .pg_w      (pg_w),
  .res_valid (res_valid),
  .res_priv  (res_priv),
  .res_allow (res_allow),
  .res_fault (res_fault)
);

// File: tb/tb_acc_priv_gate.sv
`timescale 1ns/1ps
module tb_acc_priv_gate;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cur_priv = 2'b00, prev_priv = 2'b00;
  logic       exec_rd = 1'b0, ovr_wr_en = 1'b0, ovr_wr_data = 1'b0;
  logic       acc_valid = 1'b0;
  logic [1:0] acc_kind = 2'b00;
  logic       pg_r = 1'b0, pg_w = 1'b0, pg_x = 1'b0, pg_u = 1'b0;
  logic       ovr_q, res_valid, res_allow, res_fault;
  logic [1:0] res_priv;
  logic       nu_ovr_q, nu_valid, nu_allow, nu_fault;
  logic [1:0] nu_priv;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  acc_priv_gate #(.HAS_USER(1'b1)) dut (
    .clk(clk), .rst(rst), .cur_priv(cur_priv), .prev_priv(prev_priv),
    .exec_rd(exec_rd), .ovr_wr_en(ovr_wr_en), .ovr_wr_data(ovr_wr_data),
    .ovr_q(ovr_q), .acc_valid(acc_valid), .acc_kind(acc_kind),
    .pg_r(pg_r), .pg_w(pg_w), .pg_x(pg_x), .pg_u(pg_u),
    .res_valid(res_valid), .res_priv(res_priv),
    .res_allow(res_allow), .res_fault(res_fault));

  acc_priv_gate #(.HAS_USER(1'b0)) dut_nu (
    .clk(clk), .rst(rst), .cur_priv(cur_priv), .prev_priv(prev_priv),
    .exec_rd(exec_rd), .ovr_wr_en(ovr_wr_en), .ovr_wr_data(ovr_wr_data),
    .ovr_q(nu_ovr_q), .acc_valid(acc_valid), .acc_kind(acc_kind),
    .pg_r(pg_r), .pg_w(pg_w), .pg_x(pg_x), .pg_u(pg_u),
    .res_valid(nu_valid), .res_priv(nu_priv),
    .res_allow(nu_allow), .res_fault(nu_fault));

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic write_ovr(input logic v);
    ovr_wr_en = 1'b1; ovr_wr_data = v;
    step();
    ovr_wr_en = 1'b0;
  endtask

  // present one access; page bits as {r,w,x,u}
  task automatic access(input logic [1:0] cp, input logic [1:0] pp,
                        input logic [1:0] kind, input logic [3:0] rwxu,
                        input logic xr);
    cur_priv = cp; prev_priv = pp; acc_kind = kind; exec_rd = xr;
    {pg_r, pg_w, pg_x, pg_u} = rwxu;
    acc_valid = 1'b1;
    step();
    acc_valid = 1'b0;
  endtask

  task automatic expect_res(input string req, input logic [1:0] p, input logic allow);
    chk(req, {res_valid, res_priv, res_allow}, {1'b1, p, allow});
    chk(req, {3'b0, res_fault}, {3'b0, ~allow});
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) step();
    chk("R1", {res_valid, res_allow, res_fault, ovr_q}, 4'h0);
    chk("R1", {2'b0, res_priv}, 4'h0);
    rst = 1'b0;
    step();
    chk("R1", {res_valid, res_allow, res_fault, ovr_q}, 4'h0);
  endtask

  task automatic t_ovr_write();
    // write and access in the same cycle: old value (0) applies
    ovr_wr_en = 1'b1; ovr_wr_data = 1'b1;
    cur_priv = 2'b00; prev_priv = 2'b11; acc_kind = 2'b01;
    {pg_r, pg_w, pg_x, pg_u} = 4'b0000; exec_rd = 1'b0; acc_valid = 1'b1;
    step();
    ovr_wr_en = 1'b0; acc_valid = 1'b0;
    chk("R2", {3'b0, ovr_q}, 4'h1);
    expect_res("R2 same-cycle", 2'b00, 1'b0);
    access(2'b00, 2'b11, 2'b01, 4'b0000, 1'b0);
    expect_res("R2 after write", 2'b11, 1'b1);
    write_ovr(1'b0);
    chk("R2 clear", {3'b0, ovr_q}, 4'h0);
  endtask

  task automatic t_fetch_ignores();
    write_ovr(1'b1);
    access(2'b00, 2'b11, 2'b00, 4'b0010, 1'b0);
    expect_res("R3 user fetch", 2'b00, 1'b0);
    access(2'b01, 2'b11, 2'b00, 4'b0010, 1'b0);
    expect_res("R3 super fetch", 2'b01, 1'b1);
    write_ovr(1'b0);
  endtask

  task automatic t_ldst_subst();
    access(2'b11, 2'b00, 2'b10, 4'b0100, 1'b0);
    expect_res("R4 ovr0 mach store", 2'b11, 1'b1);
    write_ovr(1'b1);
    access(2'b11, 2'b00, 2'b10, 4'b0100, 1'b0);
    expect_res("R4 ovr1 store as user", 2'b00, 1'b0);
    access(2'b01, 2'b00, 2'b01, 4'b1001, 1'b0);
    expect_res("R4 super load as user", 2'b00, 1'b1);
    access(2'b00, 2'b01, 2'b10, 4'b0100, 1'b0);
    expect_res("R4 user store as super", 2'b01, 1'b1);
    write_ovr(1'b0);
  endtask

  task automatic t_encoding();
    access(2'b10, 2'b00, 2'b01, 4'b1000, 1'b0);
    expect_res("R5 code10 no u", 2'b00, 1'b0);
    access(2'b10, 2'b00, 2'b01, 4'b1001, 1'b0);
    expect_res("R5 code10 u", 2'b00, 1'b1);
    write_ovr(1'b1);
    access(2'b11, 2'b10, 2'b10, 4'b0101, 1'b0);
    expect_res("R5 prev code10", 2'b00, 1'b1);
    write_ovr(1'b0);
  endtask

  task automatic t_machine();
    access(2'b11, 2'b00, 2'b00, 4'b0000, 1'b0);
    expect_res("R6 fetch", 2'b11, 1'b1);
    access(2'b11, 2'b00, 2'b01, 4'b0001, 1'b0);
    expect_res("R6 load", 2'b11, 1'b1);
  endtask

  task automatic t_load_exec();
    access(2'b01, 2'b00, 2'b01, 4'b0010, 1'b0);
    expect_res("R7 x-only load", 2'b01, 1'b0);
    access(2'b01, 2'b00, 2'b01, 4'b0010, 1'b1);
    expect_res("R7 x-only load xr", 2'b01, 1'b1);
    access(2'b01, 2'b00, 2'b01, 4'b0100, 1'b1);
    expect_res("R7 w-only load xr", 2'b01, 1'b0);
    access(2'b01, 2'b00, 2'b01, 4'b1000, 1'b0);
    expect_res("R7 r load", 2'b01, 1'b1);
  endtask

  task automatic t_store_fetch();
    access(2'b01, 2'b00, 2'b10, 4'b1010, 1'b1);
    expect_res("R8 store no w", 2'b01, 1'b0);
    access(2'b01, 2'b00, 2'b00, 4'b1100, 1'b0);
    expect_res("R8 fetch no x", 2'b01, 1'b0);
    access(2'b00, 2'b00, 2'b10, 4'b0101, 1'b0);
    expect_res("R8 user store w", 2'b00, 1'b1);
  endtask

  task automatic t_owner();
    access(2'b00, 2'b00, 2'b00, 4'b0010, 1'b0);
    expect_res("R9 user fetch u0", 2'b00, 1'b0);
    access(2'b01, 2'b00, 2'b00, 4'b0011, 1'b0);
    expect_res("R9 super fetch u1", 2'b01, 1'b0);
    access(2'b01, 2'b00, 2'b01, 4'b1001, 1'b0);
    expect_res("R9 super load u1", 2'b01, 1'b1);
  endtask

  task automatic t_timing();
    access(2'b11, 2'b00, 2'b01, 4'b0000, 1'b0);
    expect_res("R10 one-cycle", 2'b11, 1'b1);
    step();
    chk("R10 idle", {res_valid, res_allow, res_fault, 1'b0}, 4'h0);
  endtask

  task automatic t_reserved();
    access(2'b11, 2'b00, 2'b11, 4'b1111, 1'b1);
    expect_res("R11 mach rsvd", 2'b11, 1'b0);
    write_ovr(1'b1);
    access(2'b00, 2'b11, 2'b11, 4'b1111, 1'b0);
    expect_res("R11 rsvd cur priv", 2'b00, 1'b0);
    write_ovr(1'b0);
  endtask

  task automatic t_no_user();
    write_ovr(1'b1);
    chk("R12 tied", {2'b0, ovr_q, nu_ovr_q}, 4'b0010);
    access(2'b00, 2'b11, 2'b01, 4'b1000, 1'b0);
    chk("R12 load cur", {nu_valid, nu_priv, nu_fault}, {1'b1, 2'b00, 1'b1});
    chk("R12 gated dut", {res_valid, res_priv, res_allow}, {1'b1, 2'b11, 1'b1});
    write_ovr(1'b0);
  endtask

  initial begin
    t_reset();
    t_ovr_write();
    t_fetch_ignores();
    t_ldst_subst();
    t_encoding();
    t_machine();
    t_load_exec();
    t_store_fetch();
    t_owner();
    t_timing();
    t_reserved();
    t_no_user();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule